// File: doc/BRIEF.md
# Optical Sensing Phase Sequencer

This block paces the measurement cycle of an optical sensing front end. A free-running tick counter advances on a prescaled clock enable and wraps at a programmable terminal count, which sets the length of one pulse repetition period. Within each period, programmable compare values open four sample windows and four convert windows. The convert windows always run in the order red-LED channel, its ambient, infrared-LED channel, its ambient. A one-tick ADC reset strobe marks the start of every convert window, and a ready strobe shares the tick of the first of them.

A separate compare pair defines a power-down window over the idle stretch of the period. Four select bits pick which of four downstream blocks lose their enable while that window is high. A checker compares the programmed points against the guard margins that the blocks need to wake up again. It also checks the ordering of the phases, and raises a configuration error flag when any rule is broken.

Each conversion value is captured into a shadow register when its convert window closes. At the ready strobe, all six visible result registers take new values together: the four conversions plus the two LED-minus-ambient differences. Software can therefore read the whole bank at any time between one ready strobe and the next. In particular, the bank is steady from the first ADC reset to the second, and holds the previous period's data throughout.

Top module: `phase_seq`

## Requirements
- R1: The counter advances by one on each tick while enabled and returns to 0 on the tick after it equals `period_max`, so one period spans `period_max`+1 ticks.
- R2: Window bit i of `samp_win` (or `conv_win`) is high exactly while the count c satisfies start_i <= c < stop_i; index 0 is the red channel, 1 its ambient, 2 the infrared channel, 3 its ambient, and field i of each flat compare port occupies bits [i*CW +: CW].
- R3: `adc_rst` is high exactly while the count equals any `conv_start` value; `data_rdy` is high exactly while the count equals `conv_start` field 0, so it always coincides with the first ADC reset.
- R4: The value on `adc_data` during the last tick of convert window i is kept in a shadow register; the visible bank is `results` fields [i*DW +: DW] with 0..3 = the four conversions in index order, 4 = field0 - field1 and 5 = field2 - field3, modulo 2^DW.
- R5: All six result fields change only at the tick where the count enters `conv_start` field 0, and from then until the next such tick they hold the data from the previous period.
- R6: `pdn_win` is high exactly while pdn_start <= c < pdn_stop.
- R7: `blk_en[i]` is low exactly when `pdn_win` is high and `pdn_sel[i]` is 1; otherwise it is high.
- R8: While `enable` is low, all window outputs and strobes are low, `blk_en` is 4'hF and the count is held at 0; after `enable` rises, the count starts again at 0.
- R9: `cfg_err` is set one clock after the idle gap pdn_start - conv_stop field 3 is not larger than POST_MIN_US/TICK_US ticks (default 5).
- R10: `cfg_err` is set one clock after the lead gap (period_max+1 - pdn_stop) + samp_start field 0 is not larger than PRE_MIN_US/TICK_US ticks (default 20), or after pdn_stop exceeds period_max+1, or after pdn_stop <= pdn_start.
- R11: `cfg_err` is set one clock after any window has stop <= start, after a sample window ends later than its own convert window starts, or after a convert window ends later than the next convert window starts.
- R12: Without a tick, the count and every output derived from it stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| enable | input | 1 | Run enable; low resets the count and releases power-down |
| period_max | input | CW | Terminal count of the period |
| samp_start | input | 4*CW | Sample window start counts |
| samp_stop | input | 4*CW | Sample window end counts (exclusive) |
| conv_start | input | 4*CW | Convert window start counts |
| conv_stop | input | 4*CW | Convert window end counts (exclusive) |
| pdn_start | input | CW | Power-down window start count |
| pdn_stop | input | CW | Power-down window end count (exclusive) |
| pdn_sel | input | 4 | Per-block power-down select |
| adc_data | input | DW | Conversion value from the converter |
| samp_win | output | 4 | Sample window outputs |
| conv_win | output | 4 | Convert window outputs |
| adc_rst | output | 1 | ADC reset strobe |
| data_rdy | output | 1 | Ready strobe |
| pdn_win | output | 1 | Power-down window |
| blk_en | output | 4 | Block enables |
| results | output | 6*DW | Visible result bank |
| cfg_err | output | 1 | Configuration error flag |

## Verification
The count register is updated at the clock edge on which the tick is high. The windows, strobes and block enables are decoded from that register without further delay, so they are due in the cycle that follows the tick edge. The bench raises the tick for one clock and compares the outputs at the next falling edge. It then holds the tick low for another clock and compares the same outputs again, which shows that nothing moves without a tick. The result bank and the error flag each sit behind one register: the bank is checked after the tick that enters the first convert start, and the flag one falling edge after the configuration change. The bench derives all expected values from its own count of the ticks it has issued.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;
  localparam int NPH  = 4;  // sensing phases per period
  localparam int NRES = 6;  // visible result registers
  localparam int NBLK = 4;  // gated downstream blocks

  typedef enum logic [1:0] {
    PH_RED     = 2'd0,
    PH_RED_AMB = 2'd1,
    PH_IR      = 2'd2,
    PH_IR_AMB  = 2'd3
  } phase_e;
endpackage

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          enable,
  input  logic [CW-1:0] period_max,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nx,
  output logic          run_q,
  output logic          adv
);
  logic run_nx;

  always_comb begin
    adv    = tick & run_q;
    run_nx = enable;
    cnt_nx = cnt_q;
    if (!enable) begin
      cnt_nx = '0;
    end else if (adv) begin
      cnt_nx = (cnt_q == period_max) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      run_q <= run_nx;
    end
  end
endmodule

// File: rtl/seq_window.sv
module seq_window #(
  parameter int CW = 10
) (
  input  logic          run,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] start,
  input  logic [CW-1:0] stop,
  output logic          win
);
  assign win = run && (cnt >= start) && (cnt < stop);
endmodule

// File: rtl/seq_results.sv
module seq_results
  import phase_seq_pkg::*;
#(
  parameter int CW = 10,
  parameter int DW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [CW-1:0]     cnt_nx,
  input  logic [NPH*CW-1:0] conv_stop,
  input  logic [CW-1:0]     publish_at,
  input  logic [DW-1:0]     adc_data,
  output logic [NRES*DW-1:0] results
);
  logic [DW-1:0] shd_q  [NPH];
  logic [DW-1:0] shd_nx [NPH];
  logic [DW-1:0] res_q  [NRES];
  logic [DW-1:0] res_nx [NRES];
  logic          publish;

  assign publish = adv && (cnt_nx == publish_at);

  always_comb begin
    for (int i = 0; i < NPH; i++) begin
      shd_nx[i] = shd_q[i];
      if (adv && (cnt_nx == conv_stop[i*CW +: CW])) shd_nx[i] = adc_data;
    end
    for (int k = 0; k < NRES; k++) res_nx[k] = res_q[k];
    if (publish) begin
      for (int i = 0; i < NPH; i++) res_nx[i] = shd_q[i];
      res_nx[4] = shd_q[PH_RED] - shd_q[PH_RED_AMB];
      res_nx[5] = shd_q[PH_IR]  - shd_q[PH_IR_AMB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPH; i++)  shd_q[i] <= '0;
      for (int k = 0; k < NRES; k++) res_q[k] <= '0;
    end else begin
      for (int i = 0; i < NPH; i++)  shd_q[i] <= shd_nx[i];
      for (int k = 0; k < NRES; k++) res_q[k] <= res_nx[k];
    end
  end

  for (genvar k = 0; k < NRES; k++) begin : g_out
    assign results[k*DW +: DW] = res_q[k];
  end
endmodule

// File: rtl/seq_cfg_check.sv
module seq_cfg_check
  import phase_seq_pkg::*;
#(
  parameter int CW          = 10,
  parameter int TICK_US     = 10,
  parameter int POST_MIN_US = 50,
  parameter int PRE_MIN_US  = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     period_max,
  input  logic [NPH*CW-1:0] samp_start,
  input  logic [NPH*CW-1:0] samp_stop,
  input  logic [NPH*CW-1:0] conv_start,
  input  logic [NPH*CW-1:0] conv_stop,
  input  logic [CW-1:0]     pdn_start,
  input  logic [CW-1:0]     pdn_stop,
  output logic              cfg_err
);
  localparam int XW = CW + 2;
  localparam logic [XW-1:0] POST_LIM = XW'(POST_MIN_US / TICK_US);
  localparam logic [XW-1:0] PRE_LIM  = XW'(PRE_MIN_US / TICK_US);

  logic [XW-1:0] span, post_gap, pre_gap;
  logic          err_order, err_post, err_pre, err_nx;

  always_comb begin
    err_order = 1'b0;
    for (int i = 0; i < NPH; i++) begin
      if (samp_stop[i*CW +: CW] <= samp_start[i*CW +: CW]) err_order = 1'b1;
      if (conv_stop[i*CW +: CW] <= conv_start[i*CW +: CW]) err_order = 1'b1;
      if (samp_stop[i*CW +: CW] >  conv_start[i*CW +: CW]) err_order = 1'b1;
      if (i < NPH - 1) begin
        if (conv_stop[i*CW +: CW] > conv_start[(i+1)*CW +: CW]) err_order = 1'b1;
      end
    end
    span     = XW'(period_max) + 1'b1;
    post_gap = XW'(pdn_start) - XW'(conv_stop[(NPH-1)*CW +: CW]);
    pre_gap  = span - XW'(pdn_stop) + XW'(samp_start[CW-1:0]);
    err_post = (pdn_start < conv_stop[(NPH-1)*CW +: CW]) || (post_gap <= POST_LIM);
    err_pre  = (XW'(pdn_stop) > span) || (pdn_stop <= pdn_start) || (pre_gap <= PRE_LIM);
    err_nx   = err_order | err_post | err_pre;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= 1'b0;
    else        cfg_err <= err_nx;
  end
endmodule

// File: rtl/phase_seq.sv
module phase_seq
  import phase_seq_pkg::*;
#(
  parameter int CW          = 10,
  parameter int DW          = 12,
  parameter int TICK_US     = 10,
  parameter int POST_MIN_US = 50,
  parameter int PRE_MIN_US  = 200
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 enable,
  input  logic [CW-1:0]        period_max,
  input  logic [4*CW-1:0]      samp_start,
  input  logic [4*CW-1:0]      samp_stop,
  input  logic [4*CW-1:0]      conv_start,
  input  logic [4*CW-1:0]      conv_stop,
  input  logic [CW-1:0]        pdn_start,
  input  logic [CW-1:0]        pdn_stop,
  input  logic [3:0]           pdn_sel,
  input  logic [DW-1:0]        adc_data,
  output logic [3:0]           samp_win,
  output logic [3:0]           conv_win,
  output logic                 adc_rst,
  output logic                 data_rdy,
  output logic                 pdn_win,
  output logic [3:0]           blk_en,
  output logic [6*DW-1:0]      results,
  output logic                 cfg_err
);
  logic [CW-1:0]  cnt, cnt_nx;
  logic           run, adv;
  logic [NPH-1:0] conv_hit;

  seq_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
    .period_max(period_max), .cnt_q(cnt), .cnt_nx(cnt_nx),
    .run_q(run), .adv(adv)
  );

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    seq_window #(.CW(CW)) u_samp (
      .run(run), .cnt(cnt),
      .start(samp_start[i*CW +: CW]), .stop(samp_stop[i*CW +: CW]),
      .win(samp_win[i])
    );
    seq_window #(.CW(CW)) u_conv (
      .run(run), .cnt(cnt),
      .start(conv_start[i*CW +: CW]), .stop(conv_stop[i*CW +: CW]),
      .win(conv_win[i])
    );
    assign conv_hit[i] = run && (cnt == conv_start[i*CW +: CW]);
  end

  seq_window #(.CW(CW)) u_pdn (
    .run(run), .cnt(cnt), .start(pdn_start), .stop(pdn_stop), .win(pdn_win)
  );

  assign adc_rst  = |conv_hit;
  assign data_rdy = conv_hit[PH_RED];
  assign blk_en   = ~({NBLK{pdn_win}} & pdn_sel);

  seq_results #(.CW(CW), .DW(DW)) u_res (
    .clk(clk), .rst_n(rst_n), .adv(adv), .cnt_nx(cnt_nx),
    .conv_stop(conv_stop), .publish_at(conv_start[CW-1:0]),
    .adc_data(adc_data), .results(results)
  );

  seq_cfg_check #(
    .CW(CW), .TICK_US(TICK_US), .POST_MIN_US(POST_MIN_US), .PRE_MIN_US(PRE_MIN_US)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .period_max(period_max),
    .samp_start(samp_start), .samp_stop(samp_stop),
    .conv_start(conv_start), .conv_stop(conv_stop),
    .pdn_start(pdn_start), .pdn_stop(pdn_stop), .cfg_err(cfg_err)
  );
endmodule

// File: rtl/phase_seq_chk.sv
module phase_seq_chk #(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          enable,
  input logic [CW-1:0] cnt,
  input logic [3:0]    samp_win,
  input logic [3:0]    conv_win,
  input logic          adc_rst,
  input logic          data_rdy,
  input logic          pdn_win,
  input logic [3:0]    blk_en,
  input logic          cfg_err
);
  // R3: the ready strobe never appears without an ADC reset
  a_r3_rdy_with_rst: assert property (@(posedge clk) disable iff (!rst_n)
    data_rdy |-> adc_rst);

  // R3: the first convert window opens together with reset and ready
  a_r3_first_conv_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_win[0]) |-> (adc_rst && data_rdy));

  // R7: outside the power-down window every block stays enabled
  a_r7_idle_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn_win |-> (blk_en == 4'hF));

  // R8: one clock after enable is low, everything is quiet
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (samp_win == 4'h0 && conv_win == 4'h0 && !adc_rst &&
                 !pdn_win && blk_en == 4'hF && cnt == '0));

  // R12: the count holds between ticks
  a_r12_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick) |=> $stable(cnt));

  // R2: a valid configuration never overlaps two convert windows
  a_r2_conv_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_err |-> $onehot0(conv_win));
endmodule

bind phase_seq phase_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable), .cnt(cnt),
  .samp_win(samp_win), .conv_win(conv_win), .adc_rst(adc_rst),
  .data_rdy(data_rdy), .pdn_win(pdn_win), .blk_en(blk_en), .cfg_err(cfg_err)
);

// File: tb/phase_seq_test.sv
module phase_seq_test;
  localparam int CW  = 10;
  localparam int DW  = 12;
  localparam int PER = 100;

  logic          clk, rst_n, tick, enable;
  logic [CW-1:0] period_max, pdn_start, pdn_stop;
  logic [4*CW-1:0] samp_start, samp_stop, conv_start, conv_stop;
  logic [3:0]    pdn_sel, samp_win, conv_win, blk_en;
  logic [DW-1:0] adc_data;
  logic          adc_rst, data_rdy, pdn_win, cfg_err;
  logic [6*DW-1:0] results;

  int errors = 0, checks = 0;
  int exp_cnt = 0, pidx = 0;
  bit exp_run = 0, done = 0;
  int ss[4], se[4], cs[4], ce[4], ps, pe;

  phase_seq #(.CW(CW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
    .period_max(period_max), .samp_start(samp_start), .samp_stop(samp_stop),
    .conv_start(conv_start), .conv_stop(conv_stop), .pdn_start(pdn_start),
    .pdn_stop(pdn_stop), .pdn_sel(pdn_sel), .adc_data(adc_data),
    .samp_win(samp_win), .conv_win(conv_win), .adc_rst(adc_rst),
    .data_rdy(data_rdy), .pdn_win(pdn_win), .blk_en(blk_en),
    .results(results), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [DW-1:0] fdat(int p, int c);
    return DW'((p * 97 + c * 13 + 5) % 4096);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply_cfg();
    period_max = CW'(PER - 1);
    for (int i = 0; i < 4; i++) begin
      samp_start[i*CW +: CW] = CW'(ss[i]);
      samp_stop [i*CW +: CW] = CW'(se[i]);
      conv_start[i*CW +: CW] = CW'(cs[i]);
      conv_stop [i*CW +: CW] = CW'(ce[i]);
    end
    pdn_start = CW'(ps);
    pdn_stop  = CW'(pe);
  endtask

  task automatic good_cfg();
    for (int i = 0; i < 4; i++) begin
      ss[i] = 2 + 6 * i; se[i] = 6 + 6 * i;
      cs[i] = 6 + 6 * i; ce[i] = 8 + 6 * i;
    end
    ps = 40; pe = 80;
    apply_cfg();
  endtask

  // expected outputs from the bench's own tick count
  task automatic check_model(input string tag);
    logic [3:0] e_s, e_c, e_b;
    bit e_r, e_y, e_p;
    e_s = '0; e_c = '0; e_r = 0;
    for (int i = 0; i < 4; i++) begin
      e_s[i] = exp_run && exp_cnt >= ss[i] && exp_cnt < se[i];
      e_c[i] = exp_run && exp_cnt >= cs[i] && exp_cnt < ce[i];
      if (exp_run && exp_cnt == cs[i]) e_r = 1;
    end
    e_y = exp_run && exp_cnt == cs[0];
    e_p = exp_run && exp_cnt >= ps && exp_cnt < pe;
    e_b = ~({4{e_p}} & pdn_sel);
    chk(samp_win == e_s, "R2", {tag, " samp_win"}, samp_win, e_s);
    chk(conv_win == e_c, "R2", {tag, " conv_win"}, conv_win, e_c);
    chk(adc_rst == e_r && data_rdy == e_y, "R3", {tag, " rst/rdy"},
        {adc_rst, data_rdy}, {e_r, e_y});
    chk(pdn_win == e_p, "R6", {tag, " pdn_win"}, pdn_win, e_p);
    chk(blk_en == e_b, "R7", {tag, " blk_en"}, blk_en, e_b);
  endtask

  task automatic check_results(int p);
    logic [DW-1:0] e[6];
    for (int i = 0; i < 4; i++) e[i] = fdat(p, ce[i] - 1);
    e[4] = e[0] - e[1];
    e[5] = e[2] - e[3];
    for (int k = 0; k < 6; k++)
      chk(results[k*DW +: DW] == e[k], (k < 4) ? "R4" : "R4/R5",
          $sformatf("result %0d at count %0d", k, exp_cnt),
          results[k*DW +: DW], e[k]);
  endtask

  // one tick, then one clock without a tick (R12)
  task automatic step(input string tag);
    @(negedge clk); tick = 1'b1; adc_data = fdat(pidx, exp_cnt);
    @(negedge clk); tick = 1'b0;
    if (exp_run) begin
      if (exp_cnt == PER - 1) begin exp_cnt = 0; pidx++; end
      else exp_cnt++;
    end
    check_model(tag);
    @(negedge clk);
    check_model({tag, " R12 hold"});
  endtask

  task automatic t_reset();
    chk(samp_win == 0 && conv_win == 0 && !adc_rst && !data_rdy && !pdn_win,
        "R8", "reset outputs", {samp_win, conv_win}, 0);
    chk(blk_en == 4'hF, "R8", "reset blk_en", blk_en, 4'hF);
    chk(results == '0, "R4", "reset results", results, 0);
    chk(cfg_err == 1'b0, "R9", "reset cfg_err", cfg_err, 0);
  endtask

  task automatic t_periods();
    enable = 1'b1;
    @(negedge clk);
    exp_run = 1; exp_cnt = 0; pidx = 0;
    check_model("start");
    for (int n = 0; n < 3 * PER; n++) begin
      step("R1 run");
      if (pidx >= 1 && exp_cnt >= cs[0]) check_results(pidx - 1); // R5 stable bank
    end
  endtask

  task automatic t_partial_sel();
    pdn_sel = 4'b0101;
    while (exp_cnt != 50) step("R7 partial");
    chk(blk_en == 4'b1010, "R7", "partial select", blk_en, 4'b1010);
  endtask

  task automatic t_disable();
    enable = 1'b0;
    @(negedge clk);
    exp_run = 0; exp_cnt = 0;
    chk(blk_en == 4'hF && !pdn_win, "R8", "disable releases blocks",
        {pdn_win, blk_en}, 4'hF);
    for (int n = 0; n < 3; n++) step("R8 disabled");
    enable = 1'b1;
    @(negedge clk);
    exp_run = 1;
    check_model("R8 restart");
    step("R8 restart"); step("R8 restart");
    chk(samp_win == 4'b0001, "R8", "restart from zero", samp_win, 4'b0001);
    enable = 1'b0;
    @(negedge clk);
    exp_run = 0; exp_cnt = 0;
  endtask

  task automatic t_cfg();
    ps = 30; apply_cfg(); @(negedge clk);
    chk(cfg_err == 1'b1, "R9", "short idle gap", cfg_err, 1);
    good_cfg(); @(negedge clk);
    chk(cfg_err == 1'b0, "R9", "gap restored", cfg_err, 0);
    ps = 32; apply_cfg(); @(negedge clk);
    chk(cfg_err == 1'b0, "R9", "idle gap 6 ticks", cfg_err, 0);
    ps = 31; apply_cfg(); @(negedge clk);
    chk(cfg_err == 1'b1, "R9", "idle gap 5 ticks", cfg_err, 1);
    good_cfg(); pe = 90; apply_cfg(); @(negedge clk);
    chk(cfg_err == 1'b1, "R10", "short lead gap", cfg_err, 1);
    good_cfg(); pe = 81; apply_cfg(); @(negedge clk);
    chk(cfg_err == 1'b0, "R10", "lead gap 21 ticks", cfg_err, 0);
    good_cfg(); cs[1] = 7; apply_cfg(); @(negedge clk);
    chk(cfg_err == 1'b1, "R11", "convert overlap", cfg_err, 1);
    good_cfg(); se[2] = 19; apply_cfg(); @(negedge clk);
    chk(cfg_err == 1'b1, "R11", "sample past convert", cfg_err, 1);
    good_cfg(); @(negedge clk);
    chk(cfg_err == 1'b0, "R11", "valid again", cfg_err, 0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; enable = 1'b0; pdn_sel = 4'hF; adc_data = '0;
    good_cfg();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_periods();
    t_partial_sel();
    t_disable();
    t_cfg();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule